// File: doc/BRIEF.md
# Two-Lane Interleaved Reed-Solomon Parity Encoder

This block sits in the transmit path of a serial display link and protects one pair of lanes with a systematic Reed-Solomon code over 10-bit symbols. Each cycle it takes one symbol from each of the two lanes. It splits these symbols between two independent encoders, called even and odd, by alternating lanes from slot to slot. Each encoder computes four parity symbols over 250 information symbols, which gives a 254-symbol codeword that can correct two symbol errors.

Each lane carries a block of 256 slots. Slots 0 to 249 hold information symbols, which leave the block unchanged. Slots 250 to 254 are placeholders. The block overwrites them with five parity bytes, packed from the four parity symbols that belong to that lane. Slot 255 is reserved for a later disparity adjustment and passes through untouched. Every output appears one clock after its input. A start flag marks slot 0, and a slot without the flag takes the next index. Idle cycles stall the slot sequence.

Top module: `rs_pair_parity_enc`

## Requirements
- R1: While reset is high and on the first output cycle after it, `out_valid` and `out_par` are 0.
- R2: An input in slots 0..249 appears on both output lanes one cycle later, bit for bit, with `out_par` = 0.
- R3: At slot index i, the even codeword takes lane 0 when i is even and lane 1 when i is odd. The odd codeword takes the other lane. With its four parity symbols appended, each codeword has zero syndromes at alpha^0..alpha^3. The field is GF(2^10) with polynomial x^10+x^3+1 and alpha = x. The first symbol sent has the highest degree, and parity symbol 0 is the first parity symbol sent.
- R4: Lane 0 parity symbol j comes from the even codeword when j is even and from the odd codeword when j is odd. Lane 1 takes the opposite codeword for each j.
- R5: A lane's four parity symbols form a 40-bit word, with symbol j at bits [10j+9:10j]. Slot 250+b outputs byte b of that word (bits [8b+7:8b]) on out[7:0], with out[9:8] = 0 and `out_par` = 1, for b = 0..4.
- R6: The input values presented in placeholder slots 250..254 have no effect on any output.
- R7: Slot 255 passes through unchanged one cycle later, with `out_par` = 0.
- R8: `in_sof` forces slot index 0 and restarts both encoders, even in the middle of a block. Without `in_sof`, the index wraps from 255 back to 0 and a new block begins.
- R9: A cycle with `in_valid` = 0 does not advance the slot index, and it gives `out_valid` = 0 and `out_par` = 0 on the next cycle.
- R10: A block whose information symbols are all zero produces parity bytes that are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbols present this cycle |
| in_sof | input | 1 | This slot is slot 0 of a block |
| in_lane0 | input | 10 | Lane 0 input symbol |
| in_lane1 | input | 10 | Lane 1 input symbol |
| out_valid | output | 1 | Output symbols present |
| out_par | output | 1 | Output slot carries a parity byte |
| out_lane0 | output | 10 | Lane 0 output symbol or parity byte |
| out_lane1 | output | 10 | Lane 1 output symbol or parity byte |

## Verification
The encoders are driven with several kinds of blocks: all zeros, all ones, ramps that differ per lane, pseudo-random data, and a block with a single nonzero symbol in the last information slot. The all-zero block tests the null result. Data that differs per lane would expose a swapped even/odd assignment, and the single late symbol would expose a parity register that is cleared or latched one slot off. For each block the bench rebuilds both codewords from the port traffic and checks that all eight syndromes are zero. It repeats identical data with different placeholder contents, with idle gaps inserted, after an aborted partial block, and across an implicit wrap. In each case the parity bytes must match or stay valid.

// File: rtl/rsp_pkg.sv
`timescale 1ns/1ps
package rsp_pkg;

    localparam int SYM_W   = 10;
    localparam int K_INFO  = 250;
    localparam int NPAR    = 4;
    localparam int BYTE_W  = 8;
    localparam int PWORD_W = SYM_W * NPAR;
    localparam int NBYTES  = PWORD_W / BYTE_W;
    localparam int SLOTS   = K_INFO + NBYTES + 1;
    localparam int IDX_W   = $clog2(SLOTS);
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

    typedef logic [SYM_W-1:0]             sym_t;
    typedef logic [BYTE_W-1:0]            byte_t;
    typedef logic [IDX_W-1:0]             idx_t;
    typedef logic [NPAR-1:0][SYM_W-1:0]   par_vec_t;

    typedef enum logic [1:0] {
        SLOT_DATA     = 2'd0,
        SLOT_PARITY   = 2'd1,
        SLOT_RESERVED = 2'd2
    } slot_kind_e;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            if (x[SYM_W-1]) x = (x << 1) ^ FIELD_POLY[SYM_W-1:0];
            else            x = x << 1;
        end
        return acc;
    endfunction

    function automatic sym_t alpha_pow(input int e);
        sym_t v;
        v = sym_t'(1);
        for (int i = 0; i < e; i++) v = gf_mul(v, sym_t'(2));
        return v;
    endfunction

    // Low-order coefficients of prod (x + alpha^r), r = 0..NPAR-1; leading 1 implied.
    function automatic par_vec_t gen_coeffs();
        sym_t g [NPAR+1];
        sym_t root;
        par_vec_t res;
        for (int j = 0; j <= NPAR; j++) g[j] = '0;
        g[0] = sym_t'(1);
        for (int r = 0; r < NPAR; r++) begin
            root = alpha_pow(r);
            for (int j = NPAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
        end
        for (int j = 0; j < NPAR; j++) res[j] = g[j];
        return res;
    endfunction

    localparam par_vec_t GEN = gen_coeffs();

    function automatic slot_kind_e classify(input idx_t i);
        if (i < idx_t'(K_INFO))               return SLOT_DATA;
        else if (i < idx_t'(K_INFO + NBYTES)) return SLOT_PARITY;
        else                                  return SLOT_RESERVED;
    endfunction

endpackage

// File: rtl/rsp_slot_ctr.sv
`timescale 1ns/1ps
module rsp_slot_ctr
    import rsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    output idx_t       cur_idx,
    output slot_kind_e kind
);

    idx_t cnt;

    assign cur_idx = in_sof ? '0 : cnt;
    assign kind    = classify(cur_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (in_valid) begin
            if (cur_idx == idx_t'(SLOTS - 1)) cnt <= '0;
            else                             cnt <= cur_idx + idx_t'(1);
        end
    end

    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_sof |=> cnt == idx_t'(1)) else $error("sof restart"); // R8
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_sof && cnt == idx_t'(SLOTS - 1) |=> cnt == '0) else $error("wrap"); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cnt)) else $error("stall"); // R9

endmodule

// File: rtl/rsp_rs_lfsr.sv
`timescale 1ns/1ps
module rsp_rs_lfsr
    import rsp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     clear,
    input  sym_t     sym,
    output par_vec_t par
);

    par_vec_t rem;
    par_vec_t base;
    par_vec_t nxt;
    sym_t     fb;

    assign base = clear ? '0 : rem;
    assign fb   = sym ^ base[NPAR-1];

    for (genvar j = 0; j < NPAR; j++) begin : g_stage
        if (j == 0) begin : g_low
            assign nxt[j] = gf_mul(fb, GEN[j]);
        end else begin : g_up
            assign nxt[j] = base[j-1] ^ gf_mul(fb, GEN[j]);
        end
        // parity symbol 0 is the highest-degree remainder term
        assign par[j] = rem[NPAR-1-j];
    end

    always_ff @(posedge clk) begin
        if (rst)     rem <= '0;
        else if (en) rem <= nxt;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        en && clear && sym == '0 |=> rem == '0) else $error("clear"); // R8

endmodule

// File: rtl/rsp_parity_pack.sv
`timescale 1ns/1ps
module rsp_parity_pack
    import rsp_pkg::*;
(
    input  par_vec_t even_par,
    input  par_vec_t odd_par,
    input  idx_t     cur_idx,
    output byte_t    lane0_byte,
    output byte_t    lane1_byte
);

    logic [PWORD_W-1:0] w0;
    logic [PWORD_W-1:0] w1;
    idx_t               boff;

    for (genvar j = 0; j < NPAR; j++) begin : g_ilv
        if (j % 2 == 0) begin : g_ev
            assign w0[j*SYM_W +: SYM_W] = even_par[j];
            assign w1[j*SYM_W +: SYM_W] = odd_par[j];
        end else begin : g_od
            assign w0[j*SYM_W +: SYM_W] = odd_par[j];
            assign w1[j*SYM_W +: SYM_W] = even_par[j];
        end
    end

    assign boff = cur_idx - idx_t'(K_INFO);

    always_comb begin
        lane0_byte = '0;
        lane1_byte = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (boff == idx_t'(b)) begin
                lane0_byte = w0[b*BYTE_W +: BYTE_W];
                lane1_byte = w1[b*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/rs_pair_parity_enc.sv
`timescale 1ns/1ps
module rs_pair_parity_enc
    import rsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [SYM_W-1:0] in_lane0,
    input  logic [SYM_W-1:0] in_lane1,
    output logic             out_valid,
    output logic             out_par,
    output logic [SYM_W-1:0] out_lane0,
    output logic [SYM_W-1:0] out_lane1
);

    idx_t       cur_idx;
    slot_kind_e kind;
    logic       enc_en;
    logic       blk_first;
    sym_t       even_sym;
    sym_t       odd_sym;
    par_vec_t   even_par;
    par_vec_t   odd_par;
    byte_t      pb0;
    byte_t      pb1;

    rsp_slot_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .cur_idx  (cur_idx),
        .kind     (kind)
    );

    assign enc_en    = in_valid && (kind == SLOT_DATA);
    assign blk_first = (cur_idx == '0);
    assign even_sym  = cur_idx[0] ? in_lane1 : in_lane0;
    assign odd_sym   = cur_idx[0] ? in_lane0 : in_lane1;

    rsp_rs_lfsr u_even (
        .clk   (clk),
        .rst   (rst),
        .en    (enc_en),
        .clear (blk_first),
        .sym   (even_sym),
        .par   (even_par)
    );

    rsp_rs_lfsr u_odd (
        .clk   (clk),
        .rst   (rst),
        .en    (enc_en),
        .clear (blk_first),
        .sym   (odd_sym),
        .par   (odd_par)
    );

    rsp_parity_pack u_pack (
        .even_par   (even_par),
        .odd_par    (odd_par),
        .cur_idx    (cur_idx),
        .lane0_byte (pb0),
        .lane1_byte (pb1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_par   <= 1'b0;
            out_lane0 <= '0;
            out_lane1 <= '0;
        end else begin
            out_valid <= in_valid;
            out_par   <= 1'b0;
            if (in_valid) begin
                if (kind == SLOT_PARITY) begin
                    out_par   <= 1'b1;
                    out_lane0 <= {{(SYM_W-BYTE_W){1'b0}}, pb0};
                    out_lane1 <= {{(SYM_W-BYTE_W){1'b0}}, pb1};
                end else begin
                    out_lane0 <= in_lane0;
                    out_lane1 <= in_lane1;
                end
            end
        end
    end

    AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && kind == SLOT_DATA |=> out_valid && !out_par &&
        out_lane0 == $past(in_lane0) && out_lane1 == $past(in_lane1)) else $error("data"); // R2
    AST_PAR_CLEAN: assert property (@(posedge clk) disable iff (rst)
        in_valid && kind == SLOT_PARITY |=> out_par &&
        out_lane0[SYM_W-1:BYTE_W] == '0 && out_lane1[SYM_W-1:BYTE_W] == '0) else $error("par"); // R5
    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        in_valid && kind != SLOT_DATA |=> $stable(even_par) && $stable(odd_par)) else $error("hold"); // R6
    AST_RSV_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid && kind == SLOT_RESERVED |=> !out_par &&
        out_lane0 == $past(in_lane0) && out_lane1 == $past(in_lane1)) else $error("rsv"); // R7
    AST_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_par) else $error("idle"); // R9

endmodule

// File: tb/rs_pair_parity_enc_tb.sv
`timescale 1ns/1ps
module rs_pair_parity_enc_tb_top;

    logic       clk;
    logic       rst;
    logic       in_valid;
    logic       in_sof;
    logic [9:0] in_lane0;
    logic [9:0] in_lane1;
    logic       out_valid;
    logic       out_par;
    logic [9:0] out_lane0;
    logic [9:0] out_lane1;

    int checks = 0;
    int errors = 0;

    logic [9:0] i0 [256];
    logic [9:0] i1 [256];
    logic [9:0] o0 [256];
    logic [9:0] o1 [256];
    logic       op [256];
    logic       ov [256];
    logic [79:0] par_cap;

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] seed;
        logic [9:0]  ph;
        logic        zero_par;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{3'd0, 16'd0,    10'h000, 1'b1},
        '{3'd0, 16'd5,    10'h3FF, 1'b1},
        '{3'd1, 16'd0,    10'h155, 1'b0},
        '{3'd2, 16'd17,   10'h000, 1'b0},
        '{3'd2, 16'd901,  10'h2AA, 1'b0},
        '{3'd3, 16'd4242, 10'h0F0, 1'b0},
        '{3'd3, 16'd77,   10'h3C3, 1'b0},
        '{3'd4, 16'd1,    10'h000, 1'b0}
    };

    rs_pair_parity_enc dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_lane0  (in_lane0),
        .in_lane1  (in_lane1),
        .out_valid (out_valid),
        .out_par   (out_par),
        .out_lane0 (out_lane0),
        .out_lane1 (out_lane1)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    function automatic logic [9:0] gm(input logic [9:0] a, input logic [9:0] b);
        logic [9:0] acc;
        logic [9:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[9] ? ((x << 1) ^ 10'h009) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic [9:0] sym_gen(input int mode, input int seed, input int lane, input int i);
        int v;
        case (mode)
            0: v = 0;
            1: v = 10'h3FF;
            2: v = i * 3 + lane * 7 + seed;
            3: v = seed ^ (i * 37) ^ (lane * 613) ^ (i * i * 11);
            default: v = (i == 249 && lane == (seed & 1)) ? 10'h155 : 0;
        endcase
        return v[9:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_block(input int mode, input int seed, input logic [9:0] ph,
                             input int gap, input bit sof_first);
        int idle_bad;
        idle_bad = 0;
        for (int s = 0; s < 256; s++) begin
            if (gap > 0 && s > 0 && (s % gap) == 0) begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_lane0 = 10'h3A5;
                in_lane1 = 10'h15A;
                @(posedge clk); #1;
                if (out_valid || out_par) idle_bad++;
            end
            if (s < 250) begin
                i0[s] = sym_gen(mode, seed, 0, s);
                i1[s] = sym_gen(mode, seed, 1, s);
            end else if (s < 255) begin
                i0[s] = ph;
                i1[s] = ph ^ 10'h2C1;
            end else begin
                i0[s] = sym_gen(3, seed + 9, 0, s) ^ 10'h2A5;
                i1[s] = sym_gen(3, seed + 9, 1, s) ^ 10'h35A;
            end
            in_valid = 1'b1;
            in_sof   = (s == 0) && sof_first;
            in_lane0 = i0[s];
            in_lane1 = i1[s];
            @(posedge clk); #1;
            o0[s] = out_lane0;
            o1[s] = out_lane1;
            op[s] = out_par;
            ov[s] = out_valid;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        if (gap > 0) chk(idle_bad == 0, "R9", "idle cycles give no output", idle_bad, 0);
        for (int b = 0; b < 5; b++) begin
            par_cap[8*b +: 8]      = o0[250+b][7:0];
            par_cap[40 + 8*b +: 8] = o1[250+b][7:0];
        end
    endtask

    function automatic logic [9:0] syndrome(input bit odd, input int r);
        logic [39:0] w0;
        logic [39:0] w1;
        logic [9:0]  c;
        logic [9:0]  s;
        logic [9:0]  rt;
        w0 = par_cap[39:0];
        w1 = par_cap[79:40];
        rt = 10'(1 << r);
        s  = '0;
        for (int i = 0; i < 254; i++) begin
            if (i < 250) begin
                c = ((i % 2 == 0) != odd) ? i0[i] : i1[i];
            end else begin
                c = (((i - 250) % 2 == 0) != odd) ? w0[10*(i-250) +: 10] : w1[10*(i-250) +: 10];
            end
            s = gm(s, rt) ^ c;
        end
        return s;
    endfunction

    task automatic check_block(input string tag);
        int bad;
        logic [9:0] sv;
        bad = 0;
        for (int s = 0; s < 250; s++)
            if (o0[s] !== i0[s] || o1[s] !== i1[s] || op[s] !== 1'b0 || ov[s] !== 1'b1) bad++;
        chk(bad == 0, "R2", {tag, " data passthrough mismatches"}, bad, 0);
        bad = 0;
        for (int s = 250; s < 255; s++)
            if (op[s] !== 1'b1 || o0[s][9:8] !== 2'b00 || o1[s][9:8] !== 2'b00) bad++;
        chk(bad == 0, "R5", {tag, " parity slot flag/upper bits"}, bad, 0);
        chk(o0[255] === i0[255] && o1[255] === i1[255] && op[255] === 1'b0, "R7",
            {tag, " reserved slot"}, {o0[255], o1[255]}, {i0[255], i1[255]});
        for (int r = 0; r < 4; r++) begin
            sv = syndrome(1'b0, r);
            chk(sv == 0, "R3 R4 R5", {tag, " even syndrome"}, sv, 0);
            sv = syndrome(1'b1, r);
            chk(sv == 0, "R3 R4 R5", {tag, " odd syndrome"}, sv, 0);
        end
    endtask

    initial begin
        logic [79:0] ref_par;
        rst = 1'b1;
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_lane0 = '0;
        in_lane1 = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0 && out_par == 1'b0, "R1", "reset outputs", {out_valid, out_par}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(out_valid == 1'b0 && out_par == 1'b0, "R1", "first cycle after reset", {out_valid, out_par}, 0);

        // table of stimulus vectors
        foreach (VECS[v]) begin
            run_block(VECS[v].mode, VECS[v].seed, VECS[v].ph, 0, 1'b1);
            check_block($sformatf("vec%0d", v));
            if (VECS[v].zero_par) chk(par_cap == 0, "R10", "zero data gives zero parity", par_cap, 0);
        end

        // R6: placeholder contents ignored
        run_block(3, 1234, 10'h000, 0, 1'b1);
        ref_par = par_cap;
        run_block(3, 1234, 10'h3FF, 0, 1'b1);
        chk(par_cap == ref_par, "R6", "placeholder contents change parity", par_cap, ref_par);

        // R9: idle gaps stall the slot sequence
        run_block(3, 1234, 10'h1B7, 7, 1'b1);
        check_block("stall");
        chk(par_cap == ref_par, "R9", "parity with idle gaps", par_cap, ref_par);

        // R8: aborted partial block then restart by sof
        for (int s = 0; s < 100; s++) begin
            in_valid = 1'b1;
            in_sof   = (s == 0);
            in_lane0 = sym_gen(2, 55, 0, s);
            in_lane1 = sym_gen(2, 55, 1, s);
            @(posedge clk); #1;
        end
        run_block(3, 1234, 10'h0AA, 0, 1'b1);
        check_block("sof restart");
        chk(par_cap == ref_par, "R8", "sof mid-block restart", par_cap, ref_par);

        // R8: implicit wrap into next block without sof
        run_block(2, 300, 10'h000, 0, 1'b1);
        run_block(3, 1234, 10'h111, 0, 1'b0);
        check_block("wrap");
        chk(par_cap == ref_par, "R8", "wrap without sof", par_cap, ref_par);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule